// File: doc/BRIEF.md
# Sector Access Permission Checker

This block decides whether one memory operation on one block of a four-block sector may go ahead. The caller states the sector it has authenticated, which of the two keys (A or B) was used, and the block, operation and sixteen-byte trailer of the sector being addressed. The checker unpacks the access bits from the trailer and confirms that their true and inverted copies agree. It then picks out the three-bit condition of the addressed block and answers allow or deny one clock after the request strobe.

When the trailer block itself is read, the checker also returns the trailer as the caller should see it. Key A is always blanked. Key B is shown only when the trailer's own condition makes it readable. A trailer whose redundant access bits disagree locks its sector. The lock is sticky, and every later request to that sector is denied until the block's reset is asserted. The reset stands for the test and initialisation state.

Top module: `sector_access_checker`

## Requirements
- R1: Every request strobe `req_vld` is answered by `rsp_vld` high for exactly one cycle at the next clock edge. `rsp_allow` and `rsp_data` are zero in any cycle without `rsp_vld`.
- R2: A request is denied when `auth_vld` is low, or when `req_sector` differs from `auth_sector`.
- R3: The trailer is byte n = `trailer[8n+7:8n]`. C1[3:0] is byte 7 bits 7:4. C2[3:0] is byte 8 bits 3:0. C3[3:0] is byte 8 bits 7:4. Byte 6 must equal {~C2, ~C1} and byte 7 bits 3:0 must equal ~C3. Any request whose trailer breaks this is denied and locks `req_sector`, whether or not it is authenticated.
- R4: A locked sector denies every request until `rst_n` is asserted, even when a well-formed trailer is later presented. Other sectors are not affected.
- R5: A data block (index 0..2) with condition {C1,C2,C3} grants rights as follows, listed as read/write/increment/decrement-restore-transfer: 000 AB/AB/AB/AB, 010 AB/-/-/-, 100 AB/B/-/-, 110 AB/B/B/AB, 001 AB/-/-/AB, 011 B/B/-/-, 101 B/-/-/-, 111 -/-/-/-.
- R6: Under condition 001 a data block allows read and decrement with either key, and refuses increment and write. Under 110, increment is allowed with key B and refused with key A.
- R7: For the trailer (block 3), with trailer condition T: read is allowed to key A for T in {000,010,001} and to either key otherwise. Write is allowed to key A for T in {000,001}, to key B for T in {100,011,101}, and to no key for {010,110,111}. Value operations on the trailer are always denied.
- R8: When T is 000, 010 or 001, key B is readable, and every request authenticated with key B in that sector is denied.
- R9: Block 0 of sector 0 allows only read, whatever its access bits say.
- R10: `req_op` encodes 0 read, 1 write, 2 increment, 3 decrement, 4 restore, 5 transfer. Codes 6 and 7 are always denied.
- R11: On an allowed read of block 3, `rsp_data` bytes 0..5 are zero and bytes 6..9 are the stored bytes. Bytes 10..15 are the stored bytes when key B is readable (R8) and zero otherwise. In every other response `rsp_data` is zero.
- R12: While `rst_n` is asserted and after its release, `rsp_vld`, `rsp_allow` and `rsp_data` are zero and every sector lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also clears all sector locks |
| auth_vld | input | 1 | An authentication has succeeded |
| auth_sector | input | SEC_W (4) | Sector of the successful authentication |
| auth_key_b | input | 1 | 1 if key B was used, 0 for key A |
| req_vld | input | 1 | Request strobe |
| req_sector | input | SEC_W (4) | Sector addressed by the request |
| req_block | input | 2 | Block index within the sector (3 = trailer) |
| req_op | input | 3 | Requested operation (R10) |
| trailer | input | 128 | Stored trailer of the addressed sector |
| rsp_vld | output | 1 | Response valid, one cycle after `req_vld` |
| rsp_allow | output | 1 | Operation permitted |
| rsp_data | output | 128 | Masked trailer on an allowed trailer read, else zero |

## Verification
The embedded properties watch, on every cycle, that each strobe gets its single-cycle answer and that a lock never drops once set. They also check that a malformed trailer locks its sector and that locked, unauthenticated or mismatched-sector requests are never allowed. Key A bytes must never appear in the response, and the manufacturer block only ever grants reads. The full permission tables for data blocks and trailers, the key B readability rule and its masking, and the survival of a lock across later well-formed trailers are shown only by the bench. Its random and directed requests are compared against its own model of the tables.

// File: rtl/sac_pkg.sv
package sac_pkg;

  localparam int TRL_BYTES = 16;
  localparam int TRL_W     = TRL_BYTES * 8;
  localparam int BLK_NUM   = 4;
  localparam int BLK_W     = 2;
  localparam int TRL_IDX   = BLK_NUM - 1;

  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_WRITE    = 3'd1,
    OP_INC      = 3'd2,
    OP_DEC      = 3'd3,
    OP_RESTORE  = 3'd4,
    OP_TRANSFER = 3'd5
  } sac_op_e;

  // bit 0 grants key A, bit 1 grants key B
  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_A    = 2'b01,
    PERM_B    = 2'b10,
    PERM_AB   = 2'b11
  } sac_perm_e;

  function automatic logic perm_grants(input sac_perm_e p, input logic key_b);
    return key_b ? p[1] : p[0];
  endfunction

endpackage

// File: rtl/sac_rst_sync.sv
module sac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sac_bits_unpack.sv
module sac_bits_unpack
  import sac_pkg::*;
(
  input  logic [TRL_W-1:0]   trailer_i,
  output logic [BLK_NUM-1:0] c1_o,
  output logic [BLK_NUM-1:0] c2_o,
  output logic [BLK_NUM-1:0] c3_o,
  output logic               fmt_ok_o
);

  logic [7:0] byte6, byte7, byte8;

  assign byte6 = trailer_i[6*8 +: 8];
  assign byte7 = trailer_i[7*8 +: 8];
  assign byte8 = trailer_i[8*8 +: 8];

  // true copies
  assign c1_o = byte7[7:4];
  assign c2_o = byte8[3:0];
  assign c3_o = byte8[7:4];

  // every inverted copy must be the bitwise complement of its true copy
  always_comb begin
    fmt_ok_o = 1'b1;
    for (int i = 0; i < BLK_NUM; i++) begin
      if (byte6[i]   == c1_o[i]) fmt_ok_o = 1'b0;
      if (byte6[4+i] == c2_o[i]) fmt_ok_o = 1'b0;
      if (byte7[i]   == c3_o[i]) fmt_ok_o = 1'b0;
    end
  end

endmodule

// File: rtl/sac_rules.sv
module sac_rules
  import sac_pkg::*;
(
  input  logic [2:0] blk_cond_i,  // {C1,C2,C3} of the addressed block
  input  logic [2:0] trl_cond_i,  // {C1,C2,C3} of the trailer
  input  logic       is_trailer_i,
  input  logic       mfr_block_i,
  input  logic       key_b_i,
  input  logic [2:0] op_i,
  output logic       allow_o,
  output logic       keyb_vis_o
);

  sac_perm_e d_rd, d_wr, d_inc, d_dtr;
  sac_perm_e t_rd, t_keya_wr, t_acc_wr, t_keyb_wr, t_wr;
  sac_op_e   op;
  logic      op_known;
  logic      grant;

  always_comb begin
    unique case (blk_cond_i)
      3'b000:  begin d_rd = PERM_AB;   d_wr = PERM_AB;   d_inc = PERM_AB;   d_dtr = PERM_AB;   end
      3'b010:  begin d_rd = PERM_AB;   d_wr = PERM_NONE; d_inc = PERM_NONE; d_dtr = PERM_NONE; end
      3'b100:  begin d_rd = PERM_AB;   d_wr = PERM_B;    d_inc = PERM_NONE; d_dtr = PERM_NONE; end
      3'b110:  begin d_rd = PERM_AB;   d_wr = PERM_B;    d_inc = PERM_B;    d_dtr = PERM_AB;   end
      3'b001:  begin d_rd = PERM_AB;   d_wr = PERM_NONE; d_inc = PERM_NONE; d_dtr = PERM_AB;   end
      3'b011:  begin d_rd = PERM_B;    d_wr = PERM_B;    d_inc = PERM_NONE; d_dtr = PERM_NONE; end
      3'b101:  begin d_rd = PERM_B;    d_wr = PERM_NONE; d_inc = PERM_NONE; d_dtr = PERM_NONE; end
      default: begin d_rd = PERM_NONE; d_wr = PERM_NONE; d_inc = PERM_NONE; d_dtr = PERM_NONE; end
    endcase
  end

  always_comb begin
    unique case (trl_cond_i)
      3'b000:  begin t_rd = PERM_A;  t_keya_wr = PERM_A;    t_acc_wr = PERM_NONE; t_keyb_wr = PERM_A;    end
      3'b010:  begin t_rd = PERM_A;  t_keya_wr = PERM_NONE; t_acc_wr = PERM_NONE; t_keyb_wr = PERM_NONE; end
      3'b100:  begin t_rd = PERM_AB; t_keya_wr = PERM_B;    t_acc_wr = PERM_NONE; t_keyb_wr = PERM_B;    end
      3'b110:  begin t_rd = PERM_AB; t_keya_wr = PERM_NONE; t_acc_wr = PERM_NONE; t_keyb_wr = PERM_NONE; end
      3'b001:  begin t_rd = PERM_A;  t_keya_wr = PERM_A;    t_acc_wr = PERM_A;    t_keyb_wr = PERM_A;    end
      3'b011:  begin t_rd = PERM_AB; t_keya_wr = PERM_B;    t_acc_wr = PERM_B;    t_keyb_wr = PERM_B;    end
      3'b101:  begin t_rd = PERM_AB; t_keya_wr = PERM_NONE; t_acc_wr = PERM_B;    t_keyb_wr = PERM_NONE; end
      default: begin t_rd = PERM_AB; t_keya_wr = PERM_NONE; t_acc_wr = PERM_NONE; t_keyb_wr = PERM_NONE; end
    endcase
    t_wr = sac_perm_e'(t_keya_wr | t_acc_wr | t_keyb_wr);
  end

  // key B is readable exactly where key A may read it
  assign keyb_vis_o = (t_keyb_wr == PERM_A) || (trl_cond_i == 3'b010);

  always_comb begin
    op       = sac_op_e'(op_i);
    op_known = 1'b1;
    grant    = 1'b0;
    if (is_trailer_i) begin
      unique case (op_i)
        3'd0:    grant = perm_grants(t_rd, key_b_i);
        3'd1:    grant = perm_grants(t_wr, key_b_i);
        default: grant = 1'b0;
      endcase
    end else begin
      case (op)
        OP_READ:                        grant = perm_grants(d_rd, key_b_i);
        OP_WRITE:                       grant = perm_grants(d_wr, key_b_i) && !mfr_block_i;
        OP_INC:                         grant = perm_grants(d_inc, key_b_i) && !mfr_block_i;
        OP_DEC, OP_RESTORE, OP_TRANSFER: grant = perm_grants(d_dtr, key_b_i) && !mfr_block_i;
        default:                        op_known = 1'b0;
      endcase
    end
    allow_o = grant && op_known && !(key_b_i && keyb_vis_o);
  end

endmodule

// File: rtl/sac_trailer_mask.sv
module sac_trailer_mask
  import sac_pkg::*;
(
  input  logic [TRL_W-1:0] trailer_i,
  input  logic             keyb_vis_i,
  output logic [TRL_W-1:0] masked_o
);

  for (genvar b = 0; b < TRL_BYTES; b++) begin : g_byte
    if (b < 6) begin : g_keya
      assign masked_o[b*8 +: 8] = 8'h00;
    end else if (b < 10) begin : g_acc
      assign masked_o[b*8 +: 8] = trailer_i[b*8 +: 8];
    end else begin : g_keyb
      assign masked_o[b*8 +: 8] = keyb_vis_i ? trailer_i[b*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/sector_access_checker.sv
module sector_access_checker
  import sac_pkg::*;
#(
  parameter  int NUM_SECTORS = 16,
  localparam int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auth_vld,
  input  logic [SEC_W-1:0] auth_sector,
  input  logic             auth_key_b,
  input  logic             req_vld,
  input  logic [SEC_W-1:0] req_sector,
  input  logic [BLK_W-1:0] req_block,
  input  logic [2:0]       req_op,
  input  logic [TRL_W-1:0] trailer,
  output logic             rsp_vld,
  output logic             rsp_allow,
  output logic [TRL_W-1:0] rsp_data
);

  logic                   rst_sync_n;
  logic [BLK_NUM-1:0]     c1, c2, c3;
  logic                   fmt_ok;
  logic [2:0]             blk_cond, trl_cond;
  logic                   is_trailer, mfr_block;
  logic                   rule_allow, keyb_vis;
  logic [TRL_W-1:0]       masked;
  logic                   sec_match, locked_now;
  logic                   allow_d;
  logic [TRL_W-1:0]       data_d;
  logic [NUM_SECTORS-1:0] lock_q, lock_d;
  logic                   lock_en;

  sac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sac_bits_unpack u_unpack (
    .trailer_i (trailer),
    .c1_o      (c1),
    .c2_o      (c2),
    .c3_o      (c3),
    .fmt_ok_o  (fmt_ok)
  );

  assign blk_cond   = {c1[req_block], c2[req_block], c3[req_block]};
  assign trl_cond   = {c1[TRL_IDX], c2[TRL_IDX], c3[TRL_IDX]};
  assign is_trailer = (req_block == BLK_W'(TRL_IDX));
  assign mfr_block  = (req_sector == '0) && (req_block == '0);

  sac_rules u_rules (
    .blk_cond_i   (blk_cond),
    .trl_cond_i   (trl_cond),
    .is_trailer_i (is_trailer),
    .mfr_block_i  (mfr_block),
    .key_b_i      (auth_key_b),
    .op_i         (req_op),
    .allow_o      (rule_allow),
    .keyb_vis_o   (keyb_vis)
  );

  sac_trailer_mask u_mask (
    .trailer_i  (trailer),
    .keyb_vis_i (keyb_vis),
    .masked_o   (masked)
  );

  // next-state logic
  always_comb begin
    sec_match  = auth_vld && (req_sector == auth_sector);
    locked_now = lock_q[req_sector];
    allow_d    = req_vld && sec_match && fmt_ok && !locked_now && rule_allow;
    data_d     = (allow_d && is_trailer && (req_op == 3'd0)) ? masked : '0;
    lock_en    = req_vld && !fmt_ok;
    lock_d     = lock_q;
    lock_d[req_sector] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lock_q <= '0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_vld   <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_vld   <= req_vld;
      rsp_allow <= allow_d;
      rsp_data  <= data_d;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_vld |=> rsp_vld);
  // R1
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_vld |=> (!rsp_vld && !rsp_allow && rsp_data == '0));
  // R2
  no_auth_deny_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_vld && (!auth_vld || req_sector != auth_sector)) |=> !rsp_allow);
  // R3
  bad_fmt_lock_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_vld && !fmt_ok) |=> (lock_q[$past(req_sector)] && !rsp_allow));
  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((lock_q & $past(lock_q)) == $past(lock_q)));
  // R4
  locked_deny_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_vld && lock_q[req_sector]) |=> !rsp_allow);
  // R9
  mfr_ro_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_vld && mfr_block && req_op != 3'd0) |=> !rsp_allow);
  // R11
  keya_hidden_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_data[47:0] == '0);

endmodule

// File: tb/sim_sector_access_checker.sv
module sim_sector_access_checker;

  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         auth_vld;
  logic [3:0]   auth_sector;
  logic         auth_key_b;
  logic         req_vld;
  logic [3:0]   req_sector;
  logic [1:0]   req_block;
  logic [2:0]   req_op;
  logic [127:0] trailer;
  logic         rsp_vld;
  logic         rsp_allow;
  logic [127:0] rsp_data;

  int n_cmp;
  int n_bad;
  bit lock_m [16];
  bit done;

  sector_access_checker u0 (
    .clk, .rst_n, .auth_vld, .auth_sector, .auth_key_b,
    .req_vld, .req_sector, .req_block, .req_op, .trailer,
    .rsp_vld, .rsp_allow, .rsp_data
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] mk_trl(input logic [3:0] c1, input logic [3:0] c2,
                                          input logic [3:0] c3, input logic [47:0] ka,
                                          input logic [47:0] kb, input logic [7:0] ud);
    return {kb, ud, c3, c2, c1, ~c3, ~c2, ~c1, ka};
  endfunction

  function automatic bit m_fmt(input logic [127:0] t);
    return (t[55:48] == {~t[67:64], ~t[63:60]}) && (t[59:56] == ~t[71:68]);
  endfunction

  function automatic logic [2:0] m_cond(input logic [127:0] t, input int b);
    return {t[60+b], t[64+b], t[68+b]};
  endfunction

  function automatic bit m_kbr(input logic [2:0] tc);
    return tc == 3'b000 || tc == 3'b010 || tc == 3'b001;
  endfunction

  function automatic bit m_allow(input logic [127:0] t, input int sec, input int blk,
                                 input int op, input bit kb, input bit av, input int asec,
                                 input bit lk);
    logic [2:0] tc, bc;
    logic [7:0] row;
    logic [1:0] p;
    if (!av || asec != sec || lk || !m_fmt(t) || op > 5) return 0;
    tc = m_cond(t, 3);
    if (kb && m_kbr(tc)) return 0;
    if (blk == 3) begin
      if (op == 0) p = m_kbr(tc) ? 2'b01 : 2'b11;
      else if (op == 1) begin
        case (tc)
          3'b000, 3'b001:         p = 2'b01;
          3'b100, 3'b011, 3'b101: p = 2'b10;
          default:                p = 2'b00;
        endcase
      end else p = 2'b00;
    end else begin
      if (sec == 0 && blk == 0 && op != 0) return 0;
      bc = m_cond(t, blk);
      case (bc) // rd wr inc dtr
        3'b000:  row = 8'b11_11_11_11;
        3'b010:  row = 8'b11_00_00_00;
        3'b100:  row = 8'b11_10_00_00;
        3'b110:  row = 8'b11_10_10_11;
        3'b001:  row = 8'b11_00_00_11;
        3'b011:  row = 8'b10_10_00_00;
        3'b101:  row = 8'b10_00_00_00;
        default: row = 8'b00_00_00_00;
      endcase
      case (op)
        0:       p = row[7:6];
        1:       p = row[5:4];
        2:       p = row[3:2];
        default: p = row[1:0];
      endcase
    end
    return kb ? p[1] : p[0];
  endfunction

  function automatic logic [127:0] m_data(input logic [127:0] t, input bit ok,
                                          input int blk, input int op);
    if (!ok || blk != 3 || op != 0) return '0;
    return {m_kbr(m_cond(t, 3)) ? t[127:80] : 48'h0, t[79:48], 48'h0};
  endfunction

  task automatic cmp(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_auth(input bit av, input int sec, input bit kb);
    auth_vld = av; auth_sector = 4'(sec); auth_key_b = kb;
  endtask

  // one request, compared against the model; returns the observed allow
  task automatic do_req(input string tag, input int sec, input int blk, input int op,
                        input logic [127:0] t, output logic a);
    bit ea;
    logic [127:0] ed;
    @(negedge clk);
    req_vld = 1'b1; req_sector = 4'(sec); req_block = 2'(blk); req_op = 3'(op); trailer = t;
    ea = m_allow(t, sec, blk, op, auth_key_b, auth_vld, int'(auth_sector), lock_m[sec]);
    ed = m_data(t, ea, blk, op);
    if (!m_fmt(t)) lock_m[sec] = 1;
    @(posedge clk); #1;
    a = rsp_allow;
    cmp({tag, " R1 rsp_vld"}, 128'(rsp_vld), 128'(1));
    cmp({tag, " allow"}, 128'(rsp_allow), 128'(ea));
    cmp({tag, " R11 data"}, rsp_data, ed);
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    cmp("R12 reset vld", 128'(rsp_vld), 128'(0));
    cmp("R12 reset allow", 128'(rsp_allow), 128'(0));
    cmp("R12 reset data", rsp_data, '0);
    foreach (lock_m[i]) lock_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [127:0] t;
    int unsigned seed;
    seed = 32'd1234;
    a = $urandom(seed);
    req_vld = 0; req_sector = 0; req_block = 0; req_op = 0; trailer = '0;
    set_auth(0, 0, 0);
    @(negedge clk);
    do_reset();

    cmp("R12 idle vld", 128'(rsp_vld), 128'(0));

    // transport configuration: trailer cond 001, data 000
    t = mk_trl(4'b0000, 4'b0000, 4'b1000, 48'hA1A2A3A4A5A6, 48'hB1B2B3B4B5B6, 8'h69);
    set_auth(1, 3, 0);
    do_req("R11 transport trailer read", 3, 3, 0, t, a);
    cmp("R11 key B visible", rsp_data[127:80], 128'(48'hB1B2B3B4B5B6));
    do_req("R7 transport trailer write A", 3, 3, 1, t, a);
    cmp("R7 write A allowed", 128'(a), 128'(1));
    do_req("R7 trailer value op", 3, 3, 3, t, a);
    cmp("R7 trailer dec denied", 128'(a), 128'(0));
    set_auth(1, 3, 1);
    do_req("R8 key B readable", 3, 1, 0, t, a);
    cmp("R8 key B denied", 128'(a), 128'(0));

    // block 1 cond 001, block 2 cond 110, trailer cond 011
    t = mk_trl(4'b0100, 4'b1100, 4'b1010, 48'h111111111111, 48'h222222222222, 8'h00);
    set_auth(1, 4, 0);
    do_req("R6 001 read", 4, 1, 0, t, a);   cmp("R6 001 read A", 128'(a), 128'(1));
    do_req("R6 001 dec", 4, 1, 3, t, a);    cmp("R6 001 dec A", 128'(a), 128'(1));
    do_req("R6 001 inc", 4, 1, 2, t, a);    cmp("R6 001 inc A", 128'(a), 128'(0));
    do_req("R6 001 write", 4, 1, 1, t, a);  cmp("R6 001 write A", 128'(a), 128'(0));
    do_req("R6 110 inc A", 4, 2, 2, t, a);  cmp("R6 110 inc A", 128'(a), 128'(0));
    do_req("R11 hidden key B", 4, 3, 0, t, a);
    cmp("R11 key B zero", rsp_data[127:80], '0);
    set_auth(1, 4, 1);
    do_req("R6 110 inc B", 4, 2, 2, t, a);  cmp("R6 110 inc B", 128'(a), 128'(1));
    do_req("R10 op 6", 4, 2, 6, t, a);      cmp("R10 op6 denied", 128'(a), 128'(0));
    do_req("R10 op 7", 4, 0, 7, t, a);      cmp("R10 op7 denied", 128'(a), 128'(0));

    // manufacturer block
    t = mk_trl(4'b0000, 4'b0000, 4'b1000, 48'h0, 48'h0, 8'h0);
    set_auth(1, 0, 0);
    do_req("R9 mfr write", 0, 0, 1, t, a);  cmp("R9 write denied", 128'(a), 128'(0));
    do_req("R9 mfr read", 0, 0, 0, t, a);   cmp("R9 read allowed", 128'(a), 128'(1));
    do_req("R5 s0 b1 write", 0, 1, 1, t, a); cmp("R5 s0b1 write", 128'(a), 128'(1));

    // authentication
    set_auth(0, 2, 0);
    do_req("R2 no auth", 2, 1, 0, t, a);    cmp("R2 no auth denied", 128'(a), 128'(0));
    set_auth(1, 2, 0);
    do_req("R2 other sector", 6, 1, 0, t, a); cmp("R2 mismatch denied", 128'(a), 128'(0));

    // lock on a malformed trailer
    set_auth(1, 5, 0);
    do_req("R3 bad format", 5, 1, 0, t ^ (128'h1 << 50), a);
    cmp("R3 bad denied", 128'(a), 128'(0));
    do_req("R4 locked good trailer", 5, 1, 0, t, a);
    cmp("R4 still locked", 128'(a), 128'(0));
    set_auth(1, 6, 0);
    do_req("R4 other sector", 6, 1, 0, t, a);
    cmp("R4 neighbour free", 128'(a), 128'(1));
    do_reset();
    set_auth(1, 5, 0);
    do_req("R12 lock cleared", 5, 1, 0, t, a);
    cmp("R12 sector 5 free", 128'(a), 128'(1));

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      int sec;
      logic [127:0] rt;
      sec = int'($urandom_range(15));
      rt = mk_trl(4'($urandom), 4'($urandom), 4'($urandom),
                  {16'($urandom), 32'($urandom)}, {16'($urandom), 32'($urandom)}, 8'($urandom));
      if (sec >= 12 && $urandom_range(31) == 0) rt[55:48] = rt[55:48] ^ 8'(1 << $urandom_range(7));
      set_auth($urandom_range(7) != 0,
               ($urandom_range(3) != 0) ? sec : int'($urandom_range(15)),
               1'($urandom));
      do_req("R5 R7 random", sec, int'($urandom_range(3)), int'($urandom_range(7)), rt, a);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule